// File: doc/BRIEF.md
# Memory Fence Ordering Controller

This block sequences every memory fence in a simple out-of-order core model, and it applies the strictest possible ordering to each one. When a fence is accepted at dispatch, the block stops younger instructions from entering the out-of-order window. It then waits until the fence is the oldest uncommitted entry in the reorder buffer. Next it asks the store buffer to empty itself, retires the fence once no store is pending, and finally issues a one-cycle pipeline flush. That flush redirects fetch to the instruction that follows the fence.

The predecessor/successor bits of a fence are ignored, and so are the acquire/release annotations on other memory operations. Every fence behaves as a full read/write barrier. A later load can never observe memory before an earlier load, because everything younger than the fence is discarded and fetched again. Until the fence retires, an external flush or exception cancels it and releases the stall.

Top module: `fence_order_ctrl`

## Requirements
- R1: After reset, disp_stall, sb_drain_req, fence_commit and flush_valid are all low.
- R2: A fence is accepted in a cycle with disp_valid=1, disp_is_fence=1, disp_stall=0 and ext_flush=0. disp_stall is high from the next cycle through the cycle of the flush pulse, and low in the cycle after the pulse.
- R3: A dispatch with disp_is_fence=0 never starts a sequence, whatever disp_aqrl holds. A fence runs the same full sequence whatever disp_order_bits holds.
- R4: The accepted fence waits while rob_head_idx differs from its reorder index. During that wait sb_drain_req and fence_commit stay low.
- R5: Once the fence is oldest, a drain phase starts in the next cycle. sb_drain_req is high in every drain-phase cycle in which sb_empty=0.
- R6: If sb_empty=1 in the first drain-phase cycle, the drain phase lasts exactly one cycle and sb_drain_req stays low.
- R7: fence_commit is a one-cycle pulse in the cycle after the drain phase sees sb_empty=1. It is only ever high while sb_empty=1.
- R8: flush_valid pulses for one cycle, in the cycle right after fence_commit, with flush_target equal to the fence's dispatch PC plus 4.
- R9: An ext_flush while the fence waits or drains cancels it: disp_stall is low in the next cycle, and no commit or flush follows. A fence presented together with ext_flush is not accepted.
- R10: An ext_flush in the commit cycle has no effect, and the flush pulse still follows.
- R11: A fence presented while disp_stall=1 is ignored. It does not change the flush target and does not start a second sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| disp_valid | input | 1 | An instruction dispatches this cycle |
| disp_is_fence | input | 1 | The dispatching instruction is a fence |
| disp_order_bits | input | 8 | Fence predecessor/successor field (ignored) |
| disp_aqrl | input | 2 | Acquire/release annotation of a memory op (ignored) |
| disp_pc | input | PC_W | PC of the dispatching instruction |
| disp_rob_idx | input | IDX_W | Reorder-buffer index given to the dispatching instruction |
| rob_head_idx | input | IDX_W | Index of the oldest uncommitted reorder-buffer entry |
| sb_empty | input | 1 | Store buffer holds no pending store |
| ext_flush | input | 1 | External flush or exception |
| disp_stall | output | 1 | Blocks dispatch of younger instructions |
| sb_drain_req | output | 1 | Asks the store buffer to write out all stores |
| fence_commit | output | 1 | The fence retires this cycle |
| flush_valid | output | 1 | Pipeline flush pulse |
| flush_target | output | PC_W | Refetch address for the flush |

## Verification
The hardest situation to reach from the ports is a drain that has to wait. That needs a fence stuck behind older entries, then released into a store buffer that still holds stores, with a second fence arriving while dispatch is blocked. The stimulus holds rob_head_idx away from the fence index for several cycles and offers a second fence with another PC. It then moves the head onto the fence while sb_empty is low, and raises sb_empty only after the drain request has been seen. Cancellation is exercised separately in the waiting phase, in the draining phase and in the commit cycle.

// File: rtl/fence_order_pkg.sv
package fence_order_pkg;

    typedef enum logic [2:0] {
        FS_IDLE   = 3'd0,
        FS_WAIT   = 3'd1,
        FS_DRAIN  = 3'd2,
        FS_COMMIT = 3'd3,
        FS_FLUSH  = 3'd4
    } fence_state_e;

    typedef struct packed {
        fence_state_e state;
    } fsm_regs_t;

endpackage

// File: rtl/fence_capture.sv
module fence_capture #(
    parameter int PC_W    = 32,
    parameter int IDX_W   = 5,
    parameter int PC_STEP = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PC_W-1:0]  disp_pc,
    input  logic [IDX_W-1:0] disp_rob_idx,
    input  logic [IDX_W-1:0] rob_head_idx,
    output logic             is_oldest,
    output logic [PC_W-1:0]  redirect_pc
);

    typedef struct packed {
        logic [PC_W-1:0]  pc;
        logic [IDX_W-1:0] idx;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (load) begin
            cap_d.pc  = disp_pc;
            cap_d.idx = disp_rob_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign is_oldest   = (rob_head_idx == cap_q.idx);
    assign redirect_pc = cap_q.pc + PC_W'(PC_STEP);

endmodule

// File: rtl/fence_fsm.sv
module fence_fsm
    import fence_order_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic is_oldest,
    input  logic sb_empty,
    input  logic ext_flush,
    output logic load,
    output logic stall,
    output logic drain_req,
    output logic commit,
    output logic flush
);

    fsm_regs_t r_d, r_q;

    always_comb begin
        r_d  = r_q;
        load = 1'b0;
        unique case (r_q.state)
            FS_IDLE: begin
                if (start && !ext_flush) begin
                    r_d.state = FS_WAIT;
                    load      = 1'b1;
                end
            end
            FS_WAIT: begin
                if (ext_flush)      r_d.state = FS_IDLE;
                else if (is_oldest) r_d.state = FS_DRAIN;
            end
            FS_DRAIN: begin
                if (ext_flush)     r_d.state = FS_IDLE;
                else if (sb_empty) r_d.state = FS_COMMIT;
            end
            FS_COMMIT: r_d.state = FS_FLUSH;
            FS_FLUSH:  r_d.state = FS_IDLE;
            default:   r_d.state = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q.state <= FS_IDLE;
        else        r_q       <= r_d;
    end

    assign stall     = (r_q.state != FS_IDLE);
    assign drain_req = (r_q.state == FS_DRAIN) && !sb_empty;
    assign commit    = (r_q.state == FS_COMMIT);
    assign flush     = (r_q.state == FS_FLUSH);

endmodule

// File: rtl/fence_order_ctrl.sv
module fence_order_ctrl #(
    parameter int PC_W    = 32,
    parameter int IDX_W   = 5,
    parameter int PC_STEP = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             disp_valid,
    input  logic             disp_is_fence,
    input  logic [7:0]       disp_order_bits,
    input  logic [1:0]       disp_aqrl,
    input  logic [PC_W-1:0]  disp_pc,
    input  logic [IDX_W-1:0] disp_rob_idx,
    input  logic [IDX_W-1:0] rob_head_idx,
    input  logic             sb_empty,
    input  logic             ext_flush,
    output logic             disp_stall,
    output logic             sb_drain_req,
    output logic             fence_commit,
    output logic             flush_valid,
    output logic [PC_W-1:0]  flush_target
);

    logic start, load, is_oldest;

    // Ordering annotations are deliberately discarded: every fence is a full barrier.
    logic unused_order;
    assign unused_order = ^{disp_order_bits, disp_aqrl};

    assign start = disp_valid && disp_is_fence;

    fence_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .is_oldest (is_oldest),
        .sb_empty  (sb_empty),
        .ext_flush (ext_flush),
        .load      (load),
        .stall     (disp_stall),
        .drain_req (sb_drain_req),
        .commit    (fence_commit),
        .flush     (flush_valid)
    );

    fence_capture #(
        .PC_W    (PC_W),
        .IDX_W   (IDX_W),
        .PC_STEP (PC_STEP)
    ) u_cap (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (load),
        .disp_pc      (disp_pc),
        .disp_rob_idx (disp_rob_idx),
        .rob_head_idx (rob_head_idx),
        .is_oldest    (is_oldest),
        .redirect_pc  (flush_target)
    );

endmodule

// File: rtl/fence_order_chk.sv
module fence_order_chk (
    input logic clk,
    input logic rst_n,
    input logic ext_flush,
    input logic sb_empty,
    input logic disp_stall,
    input logic sb_drain_req,
    input logic fence_commit,
    input logic flush_valid
);

    // R5
    drain_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sb_drain_req |-> (!sb_empty && disp_stall));

    // R7
    commit_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fence_commit |-> (sb_empty && disp_stall));

    // R7
    commit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fence_commit |=> !fence_commit);

    // R8
    commit_then_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fence_commit |=> flush_valid);

    // R2
    flush_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> disp_stall);

    // R2
    release_after_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |=> !disp_stall);

    // R9
    cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_flush && disp_stall && !fence_commit && !flush_valid) |=> !disp_stall);

    // R8
    exclusive_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sb_drain_req, fence_commit, flush_valid}));

endmodule

bind fence_order_ctrl fence_order_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ext_flush    (ext_flush),
    .sb_empty     (sb_empty),
    .disp_stall   (disp_stall),
    .sb_drain_req (sb_drain_req),
    .fence_commit (fence_commit),
    .flush_valid  (flush_valid)
);

// File: tb/tb_fence_order_ctrl.sv
`timescale 1ns/1ps
module tb_fence_order_ctrl;

    localparam int PC_W  = 32;
    localparam int IDX_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             disp_valid = 1'b0;
    logic             disp_is_fence = 1'b0;
    logic [7:0]       disp_order_bits = '0;
    logic [1:0]       disp_aqrl = '0;
    logic [PC_W-1:0]  disp_pc = '0;
    logic [IDX_W-1:0] disp_rob_idx = '0;
    logic [IDX_W-1:0] rob_head_idx = '0;
    logic             sb_empty = 1'b1;
    logic             ext_flush = 1'b0;
    logic             disp_stall, sb_drain_req, fence_commit, flush_valid;
    logic [PC_W-1:0]  flush_target;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    fence_order_ctrl #(.PC_W(PC_W), .IDX_W(IDX_W)) dut (
        .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_is_fence(disp_is_fence),
        .disp_order_bits(disp_order_bits), .disp_aqrl(disp_aqrl), .disp_pc(disp_pc),
        .disp_rob_idx(disp_rob_idx), .rob_head_idx(rob_head_idx), .sb_empty(sb_empty),
        .ext_flush(ext_flush), .disp_stall(disp_stall), .sb_drain_req(sb_drain_req),
        .fence_commit(fence_commit), .flush_valid(flush_valid), .flush_target(flush_target)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk_outs(input string req, input logic st, input logic dr,
                            input logic cm, input logic fl);
        chk({req, " stall"}, 32'(disp_stall), 32'(st));
        chk({req, " drain"}, 32'(sb_drain_req), 32'(dr));
        chk({req, " commit"}, 32'(fence_commit), 32'(cm));
        chk({req, " flush"}, 32'(flush_valid), 32'(fl));
    endtask

    task automatic put_fence(input logic [31:0] pc, input logic [IDX_W-1:0] idx,
                             input logic [7:0] bits);
        disp_valid = 1'b1; disp_is_fence = 1'b1;
        disp_pc = pc; disp_rob_idx = idx; disp_order_bits = bits;
        tick();
        disp_valid = 1'b0; disp_is_fence = 1'b0;
    endtask

    task automatic t_reset();
        chk_outs("R1 reset", 0, 0, 0, 0);
    endtask

    task automatic t_basic_empty();
        rob_head_idx = 5'd3; sb_empty = 1'b1;
        put_fence(32'h100, 5'd3, 8'h00);
        chk_outs("R2 accepted", 1, 0, 0, 0);
        tick();
        chk_outs("R6 drain already empty", 1, 0, 0, 0);
        tick();
        chk_outs("R7 commit", 1, 0, 1, 0);
        tick();
        chk_outs("R8 flush", 1, 0, 0, 1);
        chk("R8 target", flush_target, 32'h104);
        tick();
        chk_outs("R2 released", 0, 0, 0, 0);
    endtask

    task automatic t_wait_drain();
        rob_head_idx = 5'd1; sb_empty = 1'b0;
        put_fence(32'h2000, 5'd5, 8'hFF);
        chk_outs("R3 order bits ignored", 1, 0, 0, 0);
        // R11: second fence offered while stalled
        disp_valid = 1'b1; disp_is_fence = 1'b1; disp_pc = 32'h3000; disp_rob_idx = 5'd9;
        tick();
        disp_valid = 1'b0; disp_is_fence = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk_outs("R4 waiting", 1, 0, 0, 0);
            tick();
        end
        rob_head_idx = 5'd5;
        tick();
        chk_outs("R5 drain request", 1, 1, 0, 0);
        tick();
        chk_outs("R5 drain held", 1, 1, 0, 0);
        sb_empty = 1'b1;
        tick();
        chk_outs("R7 commit after drain", 1, 0, 1, 0);
        tick();
        chk_outs("R8 flush after drain", 1, 0, 0, 1);
        chk("R11 target kept", flush_target, 32'h2004);
        tick();
        chk_outs("R11 no second sequence", 0, 0, 0, 0);
        tick();
        chk_outs("R11 still idle", 0, 0, 0, 0);
    endtask

    task automatic t_nonfence();
        disp_valid = 1'b1; disp_is_fence = 1'b0; disp_aqrl = 2'b11; disp_pc = 32'h400;
        tick();
        chk_outs("R3 aq/rl op", 0, 0, 0, 0);
        tick();
        chk_outs("R3 aq/rl op again", 0, 0, 0, 0);
        disp_valid = 1'b0; disp_aqrl = 2'b00;
    endtask

    task automatic t_cancel_wait();
        rob_head_idx = 5'd0; sb_empty = 1'b1;
        put_fence(32'h500, 5'd7, 8'h33);
        chk_outs("R9 wait entered", 1, 0, 0, 0);
        ext_flush = 1'b1;
        tick();
        ext_flush = 1'b0;
        chk_outs("R9 cancel in wait", 0, 0, 0, 0);
        rob_head_idx = 5'd7;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk_outs("R9 nothing after cancel", 0, 0, 0, 0);
        end
    endtask

    task automatic t_cancel_drain();
        rob_head_idx = 5'd2; sb_empty = 1'b0;
        put_fence(32'h600, 5'd2, 8'h11);
        tick();
        chk_outs("R5 drain before cancel", 1, 1, 0, 0);
        ext_flush = 1'b1;
        tick();
        ext_flush = 1'b0;
        chk_outs("R9 cancel in drain", 0, 0, 0, 0);
        sb_empty = 1'b1;
        tick();
        chk_outs("R9 no late commit", 0, 0, 0, 0);
    endtask

    task automatic t_flush_same_cycle();
        rob_head_idx = 5'd4; sb_empty = 1'b1; ext_flush = 1'b1;
        put_fence(32'h700, 5'd4, 8'h00);
        ext_flush = 1'b0;
        chk_outs("R9 not accepted with flush", 0, 0, 0, 0);
        tick();
        chk_outs("R9 still idle", 0, 0, 0, 0);
    endtask

    task automatic t_flush_late();
        rob_head_idx = 5'd6; sb_empty = 1'b1;
        put_fence(32'h800, 5'd6, 8'h00);
        tick();
        tick();
        chk_outs("R10 commit", 1, 0, 1, 0);
        ext_flush = 1'b1;
        tick();
        ext_flush = 1'b0;
        chk_outs("R10 flush still issued", 1, 0, 0, 1);
        chk("R10 target", flush_target, 32'h804);
        tick();
        chk_outs("R10 released", 0, 0, 0, 0);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) tick();
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_basic_empty();
        t_wait_drain();
        t_nonfence();
        t_cancel_wait();
        t_cancel_drain();
        t_flush_same_cycle();
        t_flush_late();
        tick();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule